// File: doc/BRIEF.md
# ECC Fault Reporting and Injection Controller

This block holds the configuration and status state that accompanies the error-correction checker of a non-volatile memory array. On every array read, the checker delivers a strobe with its single-bit and double-bit fault indications and the read address. The block turns these into sticky status flags, an error interrupt and a captured fault record. Beside the fault path, it gates a command-complete interrupt from an external command-done flag.

Software reaches the block over a small byte-wide register bus. A configuration byte selects the following behaviour:

- enabling the command-complete interrupt;
- suppressing single-bit fault reporting;
- forcing either fault flag on every read, so that interrupt handlers can be exercised without a faulty array.

Forced faults never touch the capture record. Only a real fault is recorded there, and it carries its address and kind.

Top module: `eccrep_ctrl`

## Requirements
- R1: After reset, the registers at offsets 0x4, 0x5 and 0x6 read 0x00, `cap_addr` and `cap_code` are 0, and both interrupts are low.
- R2: The configuration register is at offset 0x4. Its bits 7 (command interrupt enable), 4 (ignore single faults), 1 (force double) and 0 (force single) are written and read back. Bits 6, 5, 3 and 2 always read 0.
- R3: `irq_cmd` is high exactly when configuration bit 7 is 1 and `cmd_done` is 1.
- R4: A read strobe with `rd_sbe` high sets the single flag (status bit 0 at offset 0x6). When configuration bit 4 is 1, such a real single fault sets no flag.
- R5: A read strobe with `rd_dbe` high sets the double flag (status bit 1 at offset 0x6).
- R6: While configuration bit 0 (or bit 1) is 1, every read strobe sets the single (or double) flag, even with no fault present and even when configuration bit 4 is 1. Once the bit is 0, a fault-free read sets nothing.
- R7: Forced flags leave the capture record unchanged. The force bits stay 1 across reads until software writes 0 to them.
- R8: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. If a read sets a flag in the same cycle as a clear write, the flag stays set.
- R9: The enable register is at offset 0x5, with bit 0 for single and bit 1 for double. `irq_err` is high exactly when some flag is set together with its enable bit.
- R10: A real, reported fault is captured only while both flags are clear. The capture stores the address in `cap_addr` and the kind in `cap_code` (01 single, 10 double), and double wins when both faults occur on one read. While either flag is set, the capture record holds.
- R11: Fault indications without `rd_strobe` have no effect on the flags or the capture record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, valid while selected for read) |
| rd_strobe | input | 1 | One pulse per array read |
| rd_sbe | input | 1 | Checker found a single-bit fault |
| rd_dbe | input | 1 | Checker found a double-bit fault |
| rd_addr | input | RA_W | Address of the array read |
| cmd_done | input | 1 | Command-complete flag |
| irq_cmd | output | 1 | Command-complete interrupt |
| irq_err | output | 1 | Fault interrupt |
| cap_addr | output | RA_W | Captured fault address |
| cap_code | output | 2 | Captured fault kind |

## Verification
The hardest situation to reach is a read that sets a flag in the very cycle that software clears it. The bench drives one bus write of 1 to the status bit and a faulting read strobe in the same clock, then reads the flag back. Capture locking also needs a sequence of several reads. A first real fault opens the record, a second fault of the other kind arrives while the flag is still set, and forced-fault reads follow later. Each step checks that the record keeps its first contents.

// File: rtl/eccrep_pkg.sv
package eccrep_pkg;
  localparam int DW = 8;

  // register offsets
  localparam int OFS_CFG = 4;
  localparam int OFS_EN  = 5;
  localparam int OFS_STS = 6;

  // configuration bit positions
  localparam int B_CCIE = 7;
  localparam int B_IGN  = 4;
  localparam int B_FDF  = 1;
  localparam int B_FSF  = 0;

  // flag indices (also status/enable bit positions)
  localparam int NFLG   = 2;
  localparam int FLG_SF = 0;
  localparam int FLG_DF = 1;

  typedef struct packed {
    logic cc_ie;
    logic ign_sf;
    logic frc_df;
    logic frc_sf;
  } cfg_t;

  typedef enum logic [1:0] {
    CAP_NONE   = 2'b00,
    CAP_SINGLE = 2'b01,
    CAP_DOUBLE = 2'b10
  } cap_code_e;

  function automatic logic [DW-1:0] cfg_to_byte(cfg_t c);
    logic [DW-1:0] b;
    b         = '0;
    b[B_CCIE] = c.cc_ie;
    b[B_IGN]  = c.ign_sf;
    b[B_FDF]  = c.frc_df;
    b[B_FSF]  = c.frc_sf;
    return b;
  endfunction

  function automatic cfg_t byte_to_cfg(logic [DW-1:0] b);
    cfg_t c;
    c.cc_ie  = b[B_CCIE];
    c.ign_sf = b[B_IGN];
    c.frc_df = b[B_FDF];
    c.frc_sf = b[B_FSF];
    return c;
  endfunction
endpackage

// File: rtl/eccrep_rst_sync.sv
module eccrep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/eccrep_regs.sv
module eccrep_regs
  import eccrep_pkg::*;
#(
  parameter int NEN = NFLG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_cfg,
  input  cfg_t           cfg_wd,
  input  logic           wr_en,
  input  logic [NEN-1:0] en_wd,
  output cfg_t           cfg_q,
  output logic [NEN-1:0] en_q
);
  cfg_t           cfg_d;
  logic [NEN-1:0] en_d;

  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    if (wr_cfg) cfg_d = cfg_wd;
    if (wr_en)  en_d  = en_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_d;
      if (wr_en)  en_q  <= en_d;
    end
  end
endmodule

// File: rtl/eccrep_flags.sv
module eccrep_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set in the same cycle as a clear keeps the flag
    always_comb begin
      flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else if (set_i[i] | clr_i[i]) flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/eccrep_capture.sv
module eccrep_capture
  import eccrep_pkg::*;
#(
  parameter int RA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            real_s,
  input  logic            real_d,
  input  logic            locked,
  input  logic [RA_W-1:0] addr_i,
  output logic [RA_W-1:0] cap_addr,
  output cap_code_e       cap_code
);
  logic            cap_en;
  logic [RA_W-1:0] addr_d;
  cap_code_e       code_d;

  always_comb begin
    cap_en = (real_s | real_d) & ~locked;
    addr_d = addr_i;
    code_d = real_d ? CAP_DOUBLE : CAP_SINGLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_code <= CAP_NONE;
    end else if (cap_en) begin
      cap_addr <= addr_d;
      cap_code <= code_d;
    end
  end
endmodule

// File: rtl/eccrep_ctrl.sv
module eccrep_ctrl
  import eccrep_pkg::*;
#(
  parameter int AW   = 4,
  parameter int RA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            rd_strobe,
  input  logic            rd_sbe,
  input  logic            rd_dbe,
  input  logic [RA_W-1:0] rd_addr,
  input  logic            cmd_done,
  output logic            irq_cmd,
  output logic            irq_err,
  output logic [RA_W-1:0] cap_addr,
  output logic [1:0]      cap_code
);
  logic            rst_int_n;
  logic            acc_cfg, acc_en, acc_sts;
  logic            wr_cfg, wr_en, wr_sts;
  cfg_t            cfg_q;
  logic [NFLG-1:0] en_q;
  logic [NFLG-1:0] flag_q;
  logic [NFLG-1:0] set_vec;
  logic [NFLG-1:0] clr_vec;
  logic            real_s, real_d;
  cap_code_e       cap_code_w;
  logic            unused_wbits;

  eccrep_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // bus decode
  always_comb begin
    acc_cfg = bus_sel && (bus_addr == AW'(OFS_CFG));
    acc_en  = bus_sel && (bus_addr == AW'(OFS_EN));
    acc_sts = bus_sel && (bus_addr == AW'(OFS_STS));
    wr_cfg  = acc_cfg && bus_wr;
    wr_en   = acc_en  && bus_wr;
    wr_sts  = acc_sts && bus_wr;
  end

  assign unused_wbits = ^{bus_wdata[6:5], bus_wdata[3:2]};

  eccrep_regs #(.NEN(NFLG)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_cfg (wr_cfg),
    .cfg_wd (byte_to_cfg(bus_wdata)),
    .wr_en  (wr_en),
    .en_wd  (bus_wdata[NFLG-1:0]),
    .cfg_q  (cfg_q),
    .en_q   (en_q)
  );

  // fault classification per read
  always_comb begin
    real_s          = rd_strobe & rd_sbe & ~cfg_q.ign_sf;
    real_d          = rd_strobe & rd_dbe;
    set_vec[FLG_SF] = real_s | (rd_strobe & cfg_q.frc_sf);
    set_vec[FLG_DF] = real_d | (rd_strobe & cfg_q.frc_df);
    clr_vec         = {NFLG{wr_sts}} & bus_wdata[NFLG-1:0];
  end

  eccrep_flags #(.N(NFLG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_q (flag_q)
  );

  eccrep_capture #(.RA_W(RA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .real_s   (real_s),
    .real_d   (real_d),
    .locked   (|flag_q),
    .addr_i   (rd_addr),
    .cap_addr (cap_addr),
    .cap_code (cap_code_w)
  );

  assign cap_code = cap_code_w;
  assign irq_cmd  = cfg_q.cc_ie & cmd_done;
  assign irq_err  = |(flag_q & en_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (acc_cfg) bus_rdata = cfg_to_byte(cfg_q);
      if (acc_en)  bus_rdata[NFLG-1:0] = en_q;
      if (acc_sts) bus_rdata[NFLG-1:0] = flag_q;
    end
  end
endmodule

// File: rtl/eccrep_ctrl_chk.sv
module eccrep_ctrl_chk
  import eccrep_pkg::*;
#(
  parameter int AW   = 4,
  parameter int RA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            rd_strobe,
  input logic            rd_dbe,
  input logic            irq_cmd,
  input logic            irq_err,
  input logic [RA_W-1:0] cap_addr,
  input logic [1:0]      cap_code,
  input cfg_t            cfg_q,
  input logic [NFLG-1:0] en_q,
  input logic [NFLG-1:0] flag_q
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(OFS_CFG)) |-> ((bus_rdata & 8'h6C) == 8'h00));

  a_r3_cmd_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.cc_ie |-> !irq_cmd);

  a_r6_force_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cfg_q.frc_sf) |=> flag_q[FLG_SF]);

  a_r6_force_double: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cfg_q.frc_df) |=> flag_q[FLG_DF]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_dbe) |=> flag_q[FLG_DF]);

  a_r9_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_err);

  a_r10_cap_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |=> ($stable(cap_addr) && $stable(cap_code)));

  a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cap_code != 2'b11);
endmodule

bind eccrep_ctrl eccrep_ctrl_chk #(.AW(AW), .RA_W(RA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rd_strobe (rd_strobe),
  .rd_dbe    (rd_dbe),
  .irq_cmd   (irq_cmd),
  .irq_err   (irq_err),
  .cap_addr  (cap_addr),
  .cap_code  (cap_code),
  .cfg_q     (cfg_q),
  .en_q      (en_q),
  .flag_q    (flag_q)
);

// File: tb/eccrep_ctrl_bench.sv
module eccrep_ctrl_bench;
  localparam int AW   = 4;
  localparam int RA_W = 16;

  logic            clk;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [7:0]      bus_wdata, bus_rdata;
  logic            rd_strobe, rd_sbe, rd_dbe;
  logic [RA_W-1:0] rd_addr;
  logic            cmd_done;
  logic            irq_cmd, irq_err;
  logic [RA_W-1:0] cap_addr;
  logic [1:0]      cap_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  eccrep_ctrl #(.AW(AW), .RA_W(RA_W)) u_eccrep_ctrl (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rd_strobe, .rd_sbe, .rd_dbe, .rd_addr, .cmd_done,
    .irq_cmd, .irq_err, .cap_addr, .cap_code
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     input logic stb, input logic sbe, input logic dbe,
                     input logic [15:0] ra);
    @(negedge clk);
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    rd_strobe = stb; rd_sbe = sbe; rd_dbe = dbe; rd_addr = ra;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    rd_strobe = 0; rd_sbe = 0; rd_dbe = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic arr_rd(input logic sbe, input logic dbe, input logic [15:0] ra);
    cyc(1'b0, 4'h0, 8'h00, 1'b1, sbe, dbe, ra);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(a, v);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic chk_cap(input string req, input logic [15:0] ea, input logic [1:0] ec);
    chk(req, {16'h0, cap_addr}, {16'h0, ea});
    chk(req, {30'h0, cap_code}, {30'h0, ec});
  endtask

  task automatic t_reset;
    chk_reg("R1 cfg", 4'h4, 8'h00);
    chk_reg("R1 en", 4'h5, 8'h00);
    chk_reg("R1 sts", 4'h6, 8'h00);
    chk_cap("R1 cap", 16'h0, 2'b00);
    chk("R1 irq_cmd", {31'h0, irq_cmd}, 0);
    chk("R1 irq_err", {31'h0, irq_err}, 0);
  endtask

  task automatic t_cfg;
    wr_reg(4'h4, 8'hFF); chk_reg("R2 rw bits", 4'h4, 8'h93);
    wr_reg(4'h4, 8'h00); chk_reg("R2 clear", 4'h4, 8'h00);
    wr_reg(4'h4, 8'h6C); chk_reg("R2 reserved", 4'h4, 8'h00);
  endtask

  task automatic t_cmd;
    cmd_done = 1; #1;
    chk("R3 disabled", {31'h0, irq_cmd}, 0);
    wr_reg(4'h4, 8'h80);
    chk("R3 enabled", {31'h0, irq_cmd}, 1);
    cmd_done = 0; #1;
    chk("R3 flag low", {31'h0, irq_cmd}, 0);
    wr_reg(4'h4, 8'h00);
  endtask

  task automatic t_no_strobe;
    cyc(1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 1'b1, 16'hAAAA);
    chk_reg("R11 sts", 4'h6, 8'h00);
    chk_cap("R11 cap", 16'h0, 2'b00);
  endtask

  task automatic t_single_lock;
    arr_rd(1'b1, 1'b0, 16'h1234);
    chk_reg("R4 single flag", 4'h6, 8'h01);
    chk_cap("R10 single capture", 16'h1234, 2'b01);
    arr_rd(1'b0, 1'b1, 16'h0BEE);
    chk_reg("R5 double flag", 4'h6, 8'h03);
    chk_cap("R10 locked", 16'h1234, 2'b01);
    wr_reg(4'h6, 8'h03);
    chk_reg("R8 w1c both", 4'h6, 8'h00);
  endtask

  task automatic t_ignore;
    wr_reg(4'h4, 8'h10);
    arr_rd(1'b1, 1'b0, 16'h0055);
    chk_reg("R4 ignored", 4'h6, 8'h00);
    chk_cap("R4 ignored cap", 16'h1234, 2'b01);
    wr_reg(4'h4, 8'h00);
  endtask

  task automatic t_priority;
    arr_rd(1'b1, 1'b1, 16'h4321);
    chk_reg("R5 both flags", 4'h6, 8'h03);
    chk_cap("R10 double priority", 16'h4321, 2'b10);
    wr_reg(4'h6, 8'h03);
  endtask

  task automatic t_force;
    wr_reg(4'h4, 8'h13);
    arr_rd(1'b0, 1'b0, 16'h7777);
    chk_reg("R6 forced both", 4'h6, 8'h03);
    chk_cap("R7 no capture", 16'h4321, 2'b10);
    chk_reg("R7 force kept", 4'h4, 8'h13);
    wr_reg(4'h6, 8'h03);
    chk_reg("R8 cleared", 4'h6, 8'h00);
    arr_rd(1'b0, 1'b0, 16'h7778);
    chk_reg("R7 force persists", 4'h6, 8'h03);
    chk_cap("R7 still no capture", 16'h4321, 2'b10);
    wr_reg(4'h6, 8'h03);
    wr_reg(4'h4, 8'h10);
    arr_rd(1'b0, 1'b0, 16'h7779);
    chk_reg("R6 force off", 4'h6, 8'h00);
    wr_reg(4'h4, 8'h02);
    arr_rd(1'b0, 1'b0, 16'h777A);
    chk_reg("R6 force double only", 4'h6, 8'h02);
    wr_reg(4'h6, 8'h03);
    wr_reg(4'h4, 8'h00);
  endtask

  task automatic t_w1c;
    arr_rd(1'b1, 1'b0, 16'h0055);
    chk_reg("R4 single again", 4'h6, 8'h01);
    chk_cap("R10 recapture", 16'h0055, 2'b01);
    wr_reg(4'h6, 8'h00);
    chk_reg("R8 write 0", 4'h6, 8'h01);
    wr_reg(4'h6, 8'h02);
    chk_reg("R8 other bit", 4'h6, 8'h01);
    cyc(1'b1, 4'h6, 8'h01, 1'b1, 1'b1, 1'b0, 16'h0066);
    chk_reg("R8 set wins", 4'h6, 8'h01);
    wr_reg(4'h6, 8'h01);
    chk_reg("R8 final clear", 4'h6, 8'h00);
  endtask

  task automatic t_err_irq;
    arr_rd(1'b1, 1'b0, 16'h0BEE);
    chk("R9 no enable", {31'h0, irq_err}, 0);
    wr_reg(4'h5, 8'h01);
    chk_reg("R9 en readback", 4'h5, 8'h01);
    chk("R9 single enabled", {31'h0, irq_err}, 1);
    wr_reg(4'h5, 8'h02);
    chk("R9 wrong enable", {31'h0, irq_err}, 0);
    arr_rd(1'b0, 1'b1, 16'h0BEF);
    chk("R9 double enabled", {31'h0, irq_err}, 1);
    wr_reg(4'h6, 8'h03);
    chk("R9 cleared", {31'h0, irq_err}, 0);
    wr_reg(4'h5, 8'h00);
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rd_strobe = 0; rd_sbe = 0; rd_dbe = 0; rd_addr = 0; cmd_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_cmd();
    t_no_strobe();
    t_single_lock();
    t_ignore();
    t_priority();
    t_force();
    t_w1c();
    t_err_irq();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule